// File: doc/BRIEF.md
# Timestamp Record FIFO with Word-Serial Readout

This block buffers the event timestamp records that a packet timestamper produces for one traffic direction of one port. Each record holds a tag, a seconds value, a nanoseconds value, a clock identity, a port number and a sequence identifier. A capture source pushes the whole record in a single cycle. Host software then drains the queue one 16-bit word at a time by reading a single data register.

A status register reports three things: an enable bit that software writes, the position of the next word within the current record, and a saturating count of records that were discarded because the queue was full. The position field lets software check that it is aligned on a record boundary before it starts reading. A single not-empty output feeds a buffer-status register shared by several instances. In that shared register, transmit ports 1 to 3 sit at bits 0 to 2 and receive ports 1 to 3 sit at bits 3 to 5.

The register bus is a single-cycle strobe interface. Read data is combinational from the address. A read of the data register pops one word on the clock edge.

Top module: `ts_record_fifo`

## Requirements
- R1: After reset the queue is empty, `not_empty` is 0, and both the status register and the data register read 0.
- R2: When enabled and not full, a pushed record is stored and `not_empty` reads 1 from the next cycle on.
- R3: While the enable bit is clear, pushed records are ignored: nothing is stored and the discard count does not change.
- R4: Each record is read as 12 words in this order: tag (1), seconds (3), nanoseconds (2), clock identity (4), port number (1), sequence ID (1). Multi-word fields are delivered most significant word first.
- R5: The read position (status bits 12:8) is 0 whenever the next word is the first word of a record. Each data read increments it. The read that returns word 11 sets it back to 0 and releases the record.
- R6: A data read while the queue is empty returns 0 and changes no state.
- R7: A record pushed while enabled into a full queue is dropped, and the discard count (status bits 7:4) increments, saturating at 15.
- R8: A push in the same cycle as the read that releases a record is accepted even when the queue was full.
- R9: The queue holds up to 90 records and returns them oldest first.
- R10: The register address is 0 for status and 1 for data. A status write sets the enable bit (bit 15) from write data bit 15 and changes no other field. Writes to the data register have no effect. Unused status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_valid | input | 1 | Record push strobe |
| push_tag | input | 16 | Event tag word |
| push_sec | input | 48 | Seconds value |
| push_nsec | input | 32 | Nanoseconds value |
| push_clkid | input | 64 | Clock identity |
| push_portnum | input | 16 | Port number |
| push_seqid | input | 16 | Sequence identifier |
| reg_addr | input | 1 | Register select: 0 status, 1 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| not_empty | output | 1 | Queue holds at least one record |

## Verification
A push and the data read that releases the last word of a record can land on the same clock edge. This matters most when the queue is full, because that combination decides between accepting the record and counting a discard. The bench fills the queue to 90 records, reads eleven words of the head record, and then issues the twelfth read together with a push. The behavioural model judges the result: the new record must be stored and the discard count must stay unchanged, and a push in the following cycle must be dropped and counted. Pushes are also issued during ordinary mid-record reads, so that simultaneous push and pop away from the boundary are compared on every clock.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int STAT_W    = 16;
  localparam int EN_BIT    = 15;
  localparam int POS_W     = 5;
  localparam int DISC_W    = 4;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_DATA   = 1'b1;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic en, input logic [POS_W-1:0] pos, input logic [DISC_W-1:0] disc);
    return {en, 2'b00, pos, disc, 4'b0000};
  endfunction
endpackage

// File: rtl/tsf_rst_sync.sv
module tsf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/tsf_ring.sv
module tsf_ring #(
  parameter int DEPTH    = 90,
  parameter int REC_BITS = 192,
  parameter int CNT_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REC_BITS-1:0] wr_rec,
  input  logic                rd_release,
  output logic [REC_BITS-1:0] head_rec,
  output logic [CNT_W-1:0]    count,
  output logic                empty,
  output logic                full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [REC_BITS-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_en)      wr_ptr_d = ptr_inc(wr_ptr_q);
    if (rd_release) rd_ptr_d = ptr_inc(rd_ptr_q);
    unique case ({wr_en, rd_release})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_rec;
  end

  assign head_rec = mem[rd_ptr_q];
  assign count    = cnt_q;
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/tsf_word_mux.sv
module tsf_word_mux #(
  parameter int WORD_W    = 16,
  parameter int REC_WORDS = 12,
  parameter int POS_W     = 5
) (
  input  logic [REC_WORDS*WORD_W-1:0] rec,
  input  logic [POS_W-1:0]            pos,
  output logic [WORD_W-1:0]           word
);
  localparam int REC_BITS = REC_WORDS * WORD_W;

  logic [WORD_W-1:0] slice [REC_WORDS];

  generate
    for (genvar k = 0; k < REC_WORDS; k++) begin : g_slice
      assign slice[k] = rec[REC_BITS-1-k*WORD_W -: WORD_W];
    end
  endgenerate

  always_comb begin
    word = '0;
    for (int k = 0; k < REC_WORDS; k++) begin
      if (pos == POS_W'(k)) word = slice[k];
    end
  end
endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl #(
  parameter int REC_WORDS = 12,
  parameter int POS_W     = 5,
  parameter int DISC_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic              rd_data_stb,
  input  logic              wr_status_stb,
  input  logic              wr_en_bit,
  input  logic              empty,
  input  logic              full,
  output logic              accept,
  output logic              release_rec,
  output logic              en_q,
  output logic [POS_W-1:0]  pos_q,
  output logic [DISC_W-1:0] disc_q
);
  logic              en_d;
  logic [POS_W-1:0]  pos_d;
  logic [DISC_W-1:0] disc_d;
  logic              pop;
  logic              drop;

  always_comb begin
    pop         = rd_data_stb && !empty;
    release_rec = pop && (pos_q == POS_W'(REC_WORDS - 1));
    accept      = push_valid && en_q && (!full || release_rec);
    drop        = push_valid && en_q && full && !release_rec;

    en_d = wr_status_stb ? wr_en_bit : en_q;

    pos_d = pos_q;
    if (pop) pos_d = release_rec ? '0 : pos_q + POS_W'(1);

    disc_d = disc_q;
    if (drop && (disc_q != '1)) disc_d = disc_q + DISC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pos_q  <= '0;
      disc_q <= '0;
    end else begin
      en_q   <= en_d;
      pos_q  <= pos_d;
      disc_q <= disc_d;
    end
  end
endmodule

// File: rtl/ts_record_fifo.sv
module ts_record_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH     = 90,
  parameter int WORD_W    = 16,
  parameter int SEC_WORDS = 3,
  parameter int NS_WORDS  = 2,
  parameter int CID_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_valid,
  input  logic [WORD_W-1:0]           push_tag,
  input  logic [SEC_WORDS*WORD_W-1:0] push_sec,
  input  logic [NS_WORDS*WORD_W-1:0]  push_nsec,
  input  logic [CID_WORDS*WORD_W-1:0] push_clkid,
  input  logic [WORD_W-1:0]           push_portnum,
  input  logic [WORD_W-1:0]           push_seqid,
  input  logic                        reg_addr,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [WORD_W-1:0]           reg_wdata,
  output logic [WORD_W-1:0]           reg_rdata,
  output logic                        not_empty
);
  localparam int REC_WORDS = 3 + SEC_WORDS + NS_WORDS + CID_WORDS;
  localparam int REC_BITS  = REC_WORDS * WORD_W;
  localparam int CNT_W     = $clog2(DEPTH + 1);

  logic                rst_sync_n;
  logic [REC_BITS-1:0] push_rec;
  logic [REC_BITS-1:0] head_rec;
  logic [CNT_W-1:0]    count;
  logic                empty, full;
  logic                accept, release_rec;
  logic                en_q;
  logic [POS_W-1:0]    pos_q;
  logic [DISC_W-1:0]   disc_q;
  logic                rd_data_stb, wr_status_stb;
  logic [WORD_W-1:0]   head_word;
  logic [STAT_W-1:0]   status_word;
  logic [WORD_W-2:0]   unused_wdata;

  assign unused_wdata  = reg_wdata[WORD_W-2:0];
  assign push_rec      = {push_tag, push_sec, push_nsec, push_clkid, push_portnum, push_seqid};
  assign rd_data_stb   = reg_rd && (reg_addr == ADDR_DATA);
  assign wr_status_stb = reg_wr && (reg_addr == ADDR_STATUS);

  tsf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tsf_ring #(.DEPTH(DEPTH), .REC_BITS(REC_BITS), .CNT_W(CNT_W)) u_ring (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (accept),
    .wr_rec     (push_rec),
    .rd_release (release_rec),
    .head_rec   (head_rec),
    .count      (count),
    .empty      (empty),
    .full       (full)
  );

  tsf_ctrl #(.REC_WORDS(REC_WORDS), .POS_W(POS_W), .DISC_W(DISC_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .push_valid    (push_valid),
    .rd_data_stb   (rd_data_stb),
    .wr_status_stb (wr_status_stb),
    .wr_en_bit     (reg_wdata[WORD_W-1]),
    .empty         (empty),
    .full          (full),
    .accept        (accept),
    .release_rec   (release_rec),
    .en_q          (en_q),
    .pos_q         (pos_q),
    .disc_q        (disc_q)
  );

  tsf_word_mux #(.WORD_W(WORD_W), .REC_WORDS(REC_WORDS), .POS_W(POS_W)) u_mux (
    .rec  (head_rec),
    .pos  (pos_q),
    .word (head_word)
  );

  assign status_word = pack_status(en_q, pos_q, disc_q);

  always_comb begin
    if (reg_addr == ADDR_DATA) reg_rdata = empty ? '0 : head_word;
    else                       reg_rdata = WORD_W'(status_word);
  end

  assign not_empty = !empty;
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
  parameter int DEPTH     = 90,
  parameter int REC_WORDS = 12,
  parameter int POS_W     = 5,
  parameter int DISC_W    = 4,
  parameter int CNT_W     = 7,
  parameter int WORD_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid,
  input logic              reg_rd,
  input logic              reg_addr,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              en_q,
  input logic [POS_W-1:0]  pos_q,
  input logic [DISC_W-1:0] disc_q,
  input logic [CNT_W-1:0]  count,
  input logic              empty,
  input logic              full
);
  logic data_rd;
  assign data_rd = reg_rd && reg_addr;

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && empty) |-> (reg_rdata == '0)); // R6
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && empty && !push_valid) |=> ($stable(pos_q) && count == '0)); // R6
  AST_DISABLED_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && push_valid && !(data_rd && !empty)) |=> $stable(count)); // R3
  AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < POS_W'(REC_WORDS)); // R5
  AST_POS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (pos_q == '0)); // R5
  AST_DISC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_q == '1) |=> (disc_q == '1)); // R7
  AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (full && en_q && push_valid && !data_rd && disc_q != '1)
      |=> (disc_q == $past(disc_q) + DISC_W'(1))); // R7
  AST_RELEASE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && en_q && push_valid && data_rd && pos_q == POS_W'(REC_WORDS - 1)) |=> full); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R9
endmodule

bind ts_record_fifo tsf_checker #(
  .DEPTH(DEPTH), .REC_WORDS(REC_WORDS), .POS_W(tsf_pkg::POS_W),
  .DISC_W(tsf_pkg::DISC_W), .CNT_W(CNT_W), .WORD_W(WORD_W)
) u_tsf_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .push_valid (push_valid),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .en_q       (en_q),
  .pos_q      (pos_q),
  .disc_q     (disc_q),
  .count      (count),
  .empty      (empty),
  .full       (full)
);

// File: tb/ts_record_fifo_bench.sv
module ts_record_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 90;

  typedef struct packed {
    logic [15:0] tag;
    logic [47:0] sec;
    logic [31:0] ns;
    logic [63:0] cid;
    logic [15:0] port;
    logic [15:0] seq;
  } rec_t;

  logic clk = 1'b0;
  logic rst_n;
  logic push_valid, reg_addr, reg_wr, reg_rd;
  rec_t cur;
  logic [15:0] reg_wdata, reg_rdata;
  logic not_empty;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  rec_t q[$];
  int mpos = 0;
  int mdisc = 0;
  bit men = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_record_fifo u_ts_record_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid),
    .push_tag(cur.tag), .push_sec(cur.sec), .push_nsec(cur.ns),
    .push_clkid(cur.cid), .push_portnum(cur.port), .push_seqid(cur.seq),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .not_empty(not_empty)
  );

  function automatic rec_t mk(int i);
    rec_t r;
    r.tag  = 16'(i % 4 + 1);
    r.sec  = {16'h5EC0 ^ 16'(i), 32'(i * 7919)};
    r.ns   = 32'h3B9A_0000 + 32'(i);
    r.cid  = {32'hC1D0_0000 | 32'(i), 32'hFACE_0000 + 32'(i * 3)};
    r.port = 16'(i + 100);
    r.seq  = 16'(i * 2 + 1);
    return r;
  endfunction

  function automatic logic [15:0] exp_word(rec_t r, int p);
    case (p)
      0: return r.tag;
      1: return r.sec[47:32];
      2: return r.sec[31:16];
      3: return r.sec[15:0];
      4: return r.ns[31:16];
      5: return r.ns[15:0];
      6: return r.cid[63:48];
      7: return r.cid[47:32];
      8: return r.cid[31:16];
      9: return r.cid[15:0];
      10: return r.port;
      default: return r.seq;
    endcase
  endfunction

  function automatic logic [15:0] exp_rdata();
    if (reg_addr) return (q.size() > 0) ? exp_word(q[0], mpos) : 16'h0;
    return {men, 2'b00, 5'(mpos), 4'(mdisc), 4'b0000};
  endfunction

  task automatic check(string lbl, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", lbl, what, act, exp);
    end
  endtask

  // inputs are applied at a falling edge; outputs compared, then model advanced at the rising edge
  task automatic step(string lbl, bit pv, rec_t r, bit rd, bit wr, bit addr, logic [15:0] wd);
    bit pop, rel, acc, drop;
    push_valid = pv; cur = r; reg_rd = rd; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    #1;
    check(lbl, "rdata", reg_rdata, exp_rdata());
    check(lbl, "not_empty", {15'b0, not_empty}, {15'b0, q.size() > 0});
    @(posedge clk);
    pop  = rd && addr && q.size() > 0;
    rel  = pop && mpos == 11;
    acc  = pv && men && (q.size() < DEPTH || rel);
    drop = pv && men && q.size() == DEPTH && !rel;
    if (pop) mpos = rel ? 0 : mpos + 1;
    if (rel) void'(q.pop_front());
    if (acc) q.push_back(r);
    if (drop && mdisc < 15) mdisc++;
    if (wr && !addr) men = wd[15];
    @(negedge clk);
  endtask

  task automatic push(string lbl, rec_t r);  step(lbl, 1, r, 0, 0, 0, 16'h0); endtask
  task automatic rd_data(string lbl);        step(lbl, 0, '0, 1, 0, 1, 16'h0); endtask
  task automatic rd_stat(string lbl);        step(lbl, 0, '0, 1, 0, 0, 16'h0); endtask
  task automatic wr_stat(string lbl, logic [15:0] v); step(lbl, 0, '0, 0, 1, 0, v); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; push_valid = 0; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0; cur = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_stat("R1"); rd_data("R1");
    // R3 disabled pushes ignored
    push("R3", mk(0)); push("R3", mk(1)); rd_data("R3"); rd_stat("R3");
    // R10 status write affects only enable; data write ignored
    wr_stat("R10", 16'hFFFF); rd_stat("R10");
    wr_stat("R10", 16'h0000); rd_stat("R10");
    step("R10", 0, '0, 0, 1, 1, 16'hFFFF); rd_stat("R10");
    wr_stat("R10", 16'h8000);
    // R2 store records
    for (int i = 1; i <= 3; i++) push("R2", mk(i));
    rd_stat("R2");
    // R4/R5 word order and position
    for (int w = 0; w < 12; w++) begin rd_stat("R5"); rd_data("R4"); end
    // concurrent push with mid-record pops, data write mid-record
    for (int w = 0; w < 5; w++) step("R2", 1, mk(10 + w), 1, 0, 1, 16'h0);
    step("R10", 0, '0, 0, 1, 1, 16'h1234); rd_stat("R10");
    // drain, then R6 empty reads
    while (q.size() > 0) rd_data("R4");
    rd_stat("R5");
    for (int k = 0; k < 3; k++) rd_data("R6");
    rd_stat("R6");
    // R9 fill to capacity, R7 overflow
    n = 100;
    while (q.size() < DEPTH) begin push("R9", mk(n)); n++; end
    rd_stat("R9");
    push("R7", mk(n)); n++; rd_stat("R7");
    // R8 push coincident with releasing read while full
    for (int w = 0; w < 11; w++) rd_data("R8");
    step("R8", 1, mk(n), 1, 0, 1, 16'h0); n++;
    rd_stat("R8");
    push("R7", mk(n)); n++; rd_stat("R7");
    for (int k = 0; k < 15; k++) begin push("R7", mk(n)); n++; end
    rd_stat("R7");
    // R9 oldest-first drain
    while (q.size() > 0) rd_data("R9");
    rd_stat("R9"); rd_data("R6");
    // R3 disable again
    wr_stat("R3", 16'h0000);
    push("R3", mk(7)); rd_data("R3"); rd_stat("R3");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule